// File: doc/BRIEF.md
# Saturating Signed Up/Down Step Counter

This block holds a small signed two's complement value and moves it by one once every fixed number of system clock cycles. A direction pin chooses whether each step goes up or down. At the top and bottom of the signed range the value stays where it is; it never wraps around. The main use is a slowly changing display value, for example one step per second from a 125 MHz clock.

All logic runs on the single system clock. An internal prescaler counts cycles and produces a strobe that is high for exactly one cycle per period. That strobe is a clock enable on the count register; no divided clock is ever formed. A synchronous reset returns both the prescaler and the count to zero, and it takes priority over a pending step. The count register drives the output pins directly. There is no data stream, so the block has no valid/ready handshake; every pin is a plain control or status signal.

Top module: `sat_updown_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count becomes 0 (all bits low) after that edge and the prescaler restarts. The first step after `rst` is released therefore lands exactly `TICKS` edges later.
- R2: At a step edge with `dir_up` = 1 and the count below +7, the count increases by exactly one.
- R3: At a step edge with `dir_up` = 1 and the count at +7 (encoding 0111), the count stays at +7.
- R4: At a step edge with `dir_up` = 0 and the count above -8, the count decreases by exactly one.
- R5: At a step edge with `dir_up` = 0 and the count at -8 (encoding 1000), the count stays at -8.
- R6: Step edges occur once every `TICKS` rising edges, counted from the release of reset. The count does not change on any other edge.
- R7: `dir_up` is used only on step edges. Its value on other edges has no effect on the count.
- R8: If `rst` is high on an edge that would have been a step edge, the count goes to 0 and no step is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset for the prescaler and the count |
| dir_up | input | 1 | Step direction: 1 counts up, 0 counts down |
| count_o | output | CNT_W | Current count, signed two's complement |

## Verification
The assertions assume that `rst` and `dir_up` are already synchronous to `clk` and stable around each rising edge. They also assume the design is held in reset for at least one edge before any check applies. The bench meets these conditions by holding reset for several cycles at the start. It changes every input only on the falling clock edge and samples `count_o` on the falling edge as well. The bench model counts edges from the release of reset. It is built with a short terminal count, so that full sweeps into both saturation limits, cycle-by-cycle direction toggling, and a reset that lands on a step edge all fit in a short run.

// File: rtl/sat_cnt_pkg.sv
package sat_cnt_pkg;

  // Step direction encoding as seen on the dir_up pin.
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } step_dir_e;

  // Width of a cycle counter that must hold 0 .. limit-1.
  function automatic int unsigned tick_width(input longint unsigned limit);
    int unsigned w;
    w = 1;
    while ((longint'(1) << w) < limit) w++;
    return w;
  endfunction

endpackage

// File: rtl/sat_cnt_prescaler.sv
module sat_cnt_prescaler #(
  parameter longint unsigned TICKS = 125_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic step_en
);
  import sat_cnt_pkg::*;

  localparam int unsigned PS_W = tick_width(TICKS);
  localparam logic [PS_W-1:0] LAST = PS_W'(TICKS - 1);

  logic [PS_W-1:0] ps_q;
  logic            at_last;

  assign at_last = (ps_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q <= '0;
    end else if (at_last) begin
      ps_q <= '0;
    end else begin
      ps_q <= ps_q + 1'b1;
    end
  end

  assign step_en = at_last;

  // After a strobe the cycle count restarts at zero.
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    step_en |=> (ps_q == '0)); // R6

  // The prescaler never leaves its range.
  AST_PS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ps_q <= LAST)); // R6

  generate
    if (TICKS > 1) begin : g_pulse
      // With a period above one cycle the strobe is a single-cycle pulse.
      AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        step_en |=> !step_en); // R6
    end
  endgenerate

endmodule

// File: rtl/sat_cnt_core.sv
module sat_cnt_core #(
  parameter int unsigned CNT_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    step_en,
  input  logic                    dir_up,
  output logic signed [CNT_W-1:0] value
);
  import sat_cnt_pkg::*;

  localparam logic signed [CNT_W-1:0] TOP_V = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic signed [CNT_W-1:0] BOT_V = {1'b1, {(CNT_W-1){1'b0}}};

  step_dir_e dir;
  logic signed [CNT_W-1:0] val_q;
  logic signed [CNT_W-1:0] val_d;
  logic at_top, at_bot;

  assign dir    = step_dir_e'(dir_up);
  assign at_top = (val_q == TOP_V);
  assign at_bot = (val_q == BOT_V);

  always_comb begin
    val_d = val_q;
    if (step_en) begin
      unique case (dir)
        DIR_UP:   if (!at_top) val_d = val_q + 1'b1;
        DIR_DOWN: if (!at_bot) val_d = val_q - 1'b1;
        default:  val_d = val_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) val_q <= '0;
    else     val_q <= val_d;
  end

  assign value = val_q;

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (value == '0)); // R1

  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (step_en && dir_up && (value != TOP_V)) |=> (value == $past(value) + 1'b1)); // R2

  AST_HOLD_TOP: assert property (@(posedge clk) disable iff (rst)
    (step_en && dir_up && (value == TOP_V)) |=> (value == TOP_V)); // R3

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
    (step_en && !dir_up && (value != BOT_V)) |=> (value == $past(value) - 1'b1)); // R4

  AST_HOLD_BOT: assert property (@(posedge clk) disable iff (rst)
    (step_en && !dir_up && (value == BOT_V)) |=> (value == BOT_V)); // R5

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(value)); // R6

endmodule

// File: rtl/sat_updown_counter.sv
module sat_updown_counter #(
  parameter longint unsigned TICKS = 125_000_000,
  parameter int unsigned     CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_up,
  output logic [CNT_W-1:0] count_o
);

  logic step_en;
  logic signed [CNT_W-1:0] value;

  sat_cnt_prescaler #(.TICKS(TICKS)) u_prescaler (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en)
  );

  sat_cnt_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .dir_up  (dir_up),
    .value   (value)
  );

  assign count_o = value;

endmodule

// File: tb/sat_updown_counter_test.sv
module sat_updown_counter_test;

  localparam int T = 5;

  logic clk = 1'b0;
  logic rst;
  logic dir_up;
  logic [3:0] count_o;

  int checks = 0;
  int errors = 0;
  int m = 0;      // expected count
  int k = 0;      // edges since last step or reset

  always #10 clk = ~clk;

  sat_updown_counter #(.TICKS(T), .CNT_W(4)) uut (
    .clk(clk), .rst(rst), .dir_up(dir_up), .count_o(count_o)
  );

  task automatic cyc(input logic r, input logic d, input string tag);
    string t;
    logic signed [3:0] exp;
    rst = r;
    dir_up = d;
    t = tag;
    @(posedge clk);
    if (r) begin
      m = 0; k = 0;
    end else begin
      k++;
      if (k == T) begin
        k = 0;
        if (d) begin
          t = (m == 7) ? "R3" : "R2";
          if (m < 7) m++;
        end else begin
          t = (m == -8) ? "R5" : "R4";
          if (m > -8) m--;
        end
      end
    end
    @(negedge clk);
    exp = 4'(m);
    checks++;
    if (count_o !== exp) begin
      errors++;
      $display("FAIL %s: count_o=%0d expected=%0d", t, $signed(count_o), exp);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, "R1");
    // R1: first step exactly T edges after reset release, R6 between steps
    for (int i = 0; i < 12 * T; i++) cyc(1'b0, 1'b1, "R6");
    // down through the whole range into the lower limit
    for (int i = 0; i < 20 * T; i++) cyc(1'b0, 1'b0, "R6");
    // R7: toggle direction on non-step edges, up on step edges
    for (int i = 0; i < 6 * T; i++) cyc(1'b0, (k == T - 1) ? 1'b1 : ~dir_up, "R7");
    // R7: toggle on non-step edges, down on step edges
    for (int i = 0; i < 4 * T; i++) cyc(1'b0, (k == T - 1) ? 1'b0 : ~dir_up, "R7");
    // R8: reset lands on a step edge
    while (k != T - 1) cyc(1'b0, 1'b1, "R6");
    cyc(1'b1, 1'b1, "R8");
    for (int i = 0; i < 3 * T; i++) cyc(1'b0, 1'b1, "R6");
    // R1: reset in mid-period restarts the prescaler
    while (k != 2) cyc(1'b0, 1'b1, "R6");
    cyc(1'b1, 1'b0, "R1");
    for (int i = 0; i < 3 * T; i++) cyc(1'b0, 1'b0, "R6");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule